// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector load or store request into the stream of per-element byte addresses that the memory side needs. A request carries a base address, a vector length, an element size, an access pattern and a signed stride. The block then hands out one address per cycle over a valid/ready handshake and flags the final one. It moves no data and does no caching. It only orders addresses.

Four access patterns are supported. In contiguous mode the elements sit next to each other. In strided mode they are a fixed signed distance apart. In indexed mode each address is the base plus a byte offset that arrives on a separate index stream, one offset per element. In segmented mode interleaved records of several fields are walked record by record. The element count comes from the request at run time and is capped at a hardware maximum. It is not a fixed SIMD width.

The controller has two states. **ST_IDLE** waits for a request. The transition *accept* (request valid, clamped count non-zero) moves it to **ST_RUN**. A request with a zero count takes the transition *empty*, which stays in ST_IDLE and emits nothing. ST_RUN hands out addresses. The transition *finish* (handshake on the final address) returns it to ST_IDLE. Every other ST_RUN cycle takes *hold*.

Top module: `vaddr_seq`

## Requirements
- R1: After reset, `busy` and `addr_valid` are low.
- R2: A request is taken only while `busy` is low; `busy` rises on the clock edge that takes it. A `req_valid` pulse while `busy` is high is ignored and does not change the running sequence.
- R3: The element count is `req_vlen`, clamped to MAXVL (64). A count of zero completes at once, with no address emitted and `busy` staying low.
- R4: Mode encoding `req_mode` is 0 contiguous, 1 strided, 2 indexed, 3 segmented. `req_esize` gives the element size as 2^`req_esize` bytes (0→1, 1→2, 2→4, 3→8). In contiguous mode, address k equals base + k × element size.
- R5: In strided mode, address k equals base + k × `req_stride`. The stride is a signed two's-complement byte offset, and arithmetic wraps modulo 2^AW.
- R6: In indexed mode, address k equals base + the k-th `idx_offset` beat. `addr_valid` follows `idx_valid`. An index beat is taken (`idx_ready` high) only in the cycle its address is handed over.
- R7: In segmented mode, `req_fields` holds fields-per-record minus one. The block emits count × fields addresses in record-major order, with field f of record i at base + (i × fields + f) × element size.
- R8: An address transfers only when `addr_valid` and `addr_ready` are both high. In non-indexed modes, a stalled address stays valid and unchanged.
- R9: `addr_last` is high only together with the final valid address. `busy` falls on the clock edge that transfers it, and `addr_valid` stays low while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_base | input | AW | Base byte address |
| req_vlen | input | LW | Requested element count |
| req_esize | input | 2 | Log2 of element size in bytes |
| req_mode | input | 2 | Access pattern |
| req_stride | input | AW | Signed byte stride |
| req_fields | input | NFW | Fields per record minus one |
| idx_valid | input | 1 | Index offset beat valid |
| idx_offset | input | AW | Byte offset for the current indexed element |
| idx_ready | output | 1 | Index beat consumed |
| addr_valid | output | 1 | Address valid |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | AW | Element byte address |
| addr_last | output | 1 | Final address of the sequence |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions check the handshake rules on every cycle:
- a stalled address in a non-indexed mode stays put;
- `addr_valid` never appears while idle;
- the last flag only rides on a valid address;
- the sequence ends on the last transfer;
- index beats are consumed only with an address.

Only the bench scenarios can show the rest:
- that the address values are right for each pattern, including negative strides and wrap;
- the exact count, including clamping and zero;
- that a request arriving mid-sequence changes nothing.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT    = 2'd0,
        MODE_STRIDED = 2'd1,
        MODE_INDEXED = 2'd2,
        MODE_SEGMENT = 2'd3
    } amode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/vaddr_fsm.sv
module vaddr_fsm
    import vaddr_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int LW    = 7,
    parameter int NFW   = 3,
    parameter int TW    = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [LW-1:0]  req_vlen,
    input  logic [NFW-1:0] req_fields,
    input  logic           req_seg,
    input  logic           fire,
    output logic           accept,
    output logic           busy,
    output logic           is_last
);
    localparam logic [LW-1:0] VL_CAP = LW'(MAXVL);

    seq_state_e    state, state_nx;
    logic [TW-1:0] total_q, cnt_q;
    logic [LW-1:0] vl_clamp;
    logic [TW-1:0] total_req;
    logic          take;

    always_comb begin
        vl_clamp  = (req_vlen > VL_CAP) ? VL_CAP : req_vlen;
        total_req = req_seg ? TW'(TW'(vl_clamp) * (TW'(req_fields) + TW'(1)))
                            : TW'(vl_clamp);
    end

    // state register and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt_q   <= '0;
            total_q <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                cnt_q   <= '0;
                total_q <= total_req;
            end else if (fire) begin
                cnt_q <= cnt_q + TW'(1);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid && total_req != '0) begin
                    take     = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fire && is_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign accept  = take;
    assign busy    = (state == ST_RUN);
    assign is_last = busy && (cnt_q == total_q - TW'(1));

endmodule

// File: rtl/vaddr_datapath.sv
module vaddr_datapath
    import vaddr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          fire,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_stride,
    input  logic [1:0]    req_esize,
    input  amode_e        req_mode,
    input  logic [AW-1:0] idx_offset,
    output amode_e        mode_q,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] base_q, cur_q, step_q, step_req;

    always_comb begin
        if (req_mode == MODE_STRIDED) step_req = req_stride;
        else                          step_req = AW'(1) << req_esize;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
            step_q <= '0;
            mode_q <= MODE_UNIT;
        end else if (load) begin
            base_q <= req_base;
            cur_q  <= req_base;
            step_q <= step_req;
            mode_q <= req_mode;
        end else if (fire) begin
            cur_q <= cur_q + step_q;
        end
    end

    assign addr = (mode_q == MODE_INDEXED) ? base_q + idx_offset : cur_q;

endmodule

// File: rtl/vaddr_seq.sv
module vaddr_seq
    import vaddr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int MAXVL = 64,
    parameter int MAXNF = 8,
    parameter int LW    = $clog2(MAXVL + 1),
    parameter int NFW   = $clog2(MAXNF)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_base,
    input  logic [LW-1:0]  req_vlen,
    input  logic [1:0]     req_esize,
    input  logic [1:0]     req_mode,
    input  logic [AW-1:0]  req_stride,
    input  logic [NFW-1:0] req_fields,
    input  logic           idx_valid,
    input  logic [AW-1:0]  idx_offset,
    output logic           idx_ready,
    output logic           addr_valid,
    input  logic           addr_ready,
    output logic [AW-1:0]  addr_out,
    output logic           addr_last,
    output logic           busy
);
    localparam int TW = $clog2(MAXVL * MAXNF + 1);

    amode_e mode_in, mode_q;
    logic   accept, fire, is_last;

    assign mode_in = amode_e'(req_mode);

    vaddr_fsm #(.MAXVL(MAXVL), .LW(LW), .NFW(NFW), .TW(TW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vlen   (req_vlen),
        .req_fields (req_fields),
        .req_seg    (mode_in == MODE_SEGMENT),
        .fire       (fire),
        .accept     (accept),
        .busy       (busy),
        .is_last    (is_last)
    );

    vaddr_datapath #(.AW(AW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .fire       (fire),
        .req_base   (req_base),
        .req_stride (req_stride),
        .req_esize  (req_esize),
        .req_mode   (mode_in),
        .idx_offset (idx_offset),
        .mode_q     (mode_q),
        .addr       (addr_out)
    );

    assign addr_valid = busy && ((mode_q != MODE_INDEXED) || idx_valid);
    assign fire       = addr_valid && addr_ready;
    assign idx_ready  = busy && (mode_q == MODE_INDEXED) && addr_ready;
    assign addr_last  = addr_valid && is_last;

endmodule

// File: rtl/vaddr_seq_chk.sv
module vaddr_seq_chk
    import vaddr_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          addr_valid,
    input logic          addr_ready,
    input logic          addr_last,
    input logic [AW-1:0] addr_out,
    input logic          idx_valid,
    input logic          idx_ready,
    input amode_e        mode_q
);
    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && mode_q != MODE_INDEXED) |=> (addr_valid && $stable(addr_out))); // R8

    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !addr_valid); // R9

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid); // R9

    AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_last && addr_ready) |=> !busy); // R9

    AST_INDEX_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ready && idx_valid) |-> (addr_valid && addr_ready)); // R6

endmodule

bind vaddr_seq vaddr_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr_last  (addr_last),
    .addr_out   (addr_out),
    .idx_valid  (idx_valid),
    .idx_ready  (idx_ready),
    .mode_q     (mode_q)
);

// File: tb/vaddr_seq_test.sv
module vaddr_seq_test;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_base = '0;
    logic [6:0]  req_vlen = '0;
    logic [1:0]  req_esize = '0;
    logic [1:0]  req_mode = '0;
    logic [31:0] req_stride = '0;
    logic [2:0]  req_fields = '0;
    logic        idx_valid = 1'b0;
    logic [31:0] idx_offset = '0;
    logic        idx_ready;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr_out;
    logic        addr_last;
    logic        busy;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] idx_tab [0:511];

    always #5 clk = ~clk;

    vaddr_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_vlen(req_vlen), .req_esize(req_esize), .req_mode(req_mode),
        .req_stride(req_stride), .req_fields(req_fields), .idx_valid(idx_valid),
        .idx_offset(idx_offset), .idx_ready(idx_ready), .addr_valid(addr_valid),
        .addr_ready(addr_ready), .addr_out(addr_out), .addr_last(addr_last), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int mode, input int vlen, input int fcode);
        int vl;
        vl = (vlen > 64) ? 64 : vlen;
        return (mode == 3) ? vl * (fcode + 1) : vl;
    endfunction

    function automatic logic [31:0] exp_addr(input int mode, input logic [31:0] base,
            input int esize, input logic [31:0] stride, input int k, input logic [31:0] off);
        logic [31:0] esz;
        esz = 32'd1 << esize;
        case (mode)
            1: return base + stride * 32'(k);
            2: return base + off;
            default: return base + esz * 32'(k);
        endcase
    endfunction

    task automatic run_req(input int mode, input logic [31:0] base, input int vlen,
            input int esize, input logic [31:0] stride, input int fcode, input bit intrude);
        int n;
        int k;
        int guard;
        string tag;
        n = exp_count(mode, vlen, fcode);
        tag = (mode == 0) ? "R4" : (mode == 1) ? "R5" : (mode == 2) ? "R6" : "R7";
        for (int i = 0; i < 512; i++) idx_tab[i] = $urandom & 32'hFFFF;
        @(negedge clk);
        addr_ready = 1'b0; idx_valid = 1'b0;
        req_base = base; req_vlen = 7'(vlen); req_esize = 2'(esize);
        req_mode = 2'(mode); req_stride = stride; req_fields = 3'(fcode);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == (n != 0), "R2 busy after request", 32'(busy), 32'(n != 0));
        if (n == 0) check(!addr_valid, "R3 zero count emits nothing", 32'(addr_valid), 32'd0);
        k = 0; guard = 0;
        while (k < n && guard < 6000) begin
            @(negedge clk);
            guard++;
            addr_ready = ($urandom % 4) != 0;
            idx_valid  = ($urandom % 3) != 0;
            idx_offset = idx_tab[k];
            if (intrude) begin
                req_valid = ($urandom % 5) == 0;
                req_base = $urandom; req_vlen = 7'd3; req_mode = 2'($urandom);
                req_stride = $urandom;
            end
            #1;
            if (addr_valid && addr_ready) begin
                check(addr_out == exp_addr(mode, base, esize, stride, k, idx_tab[k]),
                      intrude ? "R2 address under ignored request" : tag,
                      addr_out, exp_addr(mode, base, esize, stride, k, idx_tab[k]));
                check(addr_last == (k == n - 1), "R9 last flag", 32'(addr_last), 32'(k == n - 1));
                if (mode == 2) check(idx_ready, "R6 index consumed with address", 32'(idx_ready), 32'd1);
                k++;
            end else if (mode == 2 && idx_ready && idx_valid) begin
                check(1'b0, "R6 index taken without address", 32'(idx_ready), 32'd0);
            end
            if (!addr_ready && mode == 2)
                check(!idx_ready, "R8 no index take without ready", 32'(idx_ready), 32'd0);
        end
        req_valid = 1'b0;
        check(k == n, "R3 address count", 32'(k), 32'(n));
        @(negedge clk);
        addr_ready = 1'b0; idx_valid = 1'b0;
        #1;
        check(!busy && !addr_valid, "R9 idle after last", {busy, addr_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!busy && !addr_valid, "R1 reset state", {busy, addr_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !addr_valid, "R1 after reset release", {busy, addr_valid}, 32'd0);

        // directed corner cases
        run_req(0, 32'h1000, 0, 2, 0, 0, 0);             // R3 zero count
        run_req(0, 32'h1000, 1, 2, 0, 0, 0);             // R4 single element
        run_req(0, 32'h2000, 64, 3, 0, 0, 0);            // R4 full length
        run_req(0, 32'h3000, 100, 0, 0, 0, 0);           // R3 clamp
        run_req(1, 32'h8000, 10, 2, 32'hFFFF_FFF0, 0, 0); // R5 negative stride
        run_req(1, 32'hFFFF_FFF0, 8, 0, 32'd12, 0, 0);   // R5 wrap
        run_req(2, 32'h4000, 20, 1, 0, 0, 0);            // R6
        run_req(3, 32'h5000, 5, 0, 0, 2, 0);             // R7 three fields, 1 byte
        run_req(3, 32'h6000, 64, 3, 0, 7, 0);            // R7 largest
        run_req(3, 32'h7000, 0, 1, 0, 3, 0);             // R3 zero segmented
        run_req(1, 32'h9000, 12, 1, 32'd24, 0, 1);       // R2 intrusion

        // random mix
        for (int t = 0; t < 60; t++) begin
            run_req(int'($urandom % 4), $urandom, int'($urandom % 72),
                    int'($urandom % 4), $urandom, int'($urandom % 8), ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule